// File: doc/BRIEF.md
# Receive Frame Statistics Counter Bank

This block keeps six wrapping statistics counters for a receive frame path whose frames leave on an MII-style output. The upstream logic raises a one-cycle end-of-frame strobe together with its result flags: FIFO underrun, FIFO overflow, too-short frame, too-long frame, FCS error, HEC error and unrecognized control flag. A checking-enable bit sits beside them. On each strobe the block files the frame under exactly one counter. Error causes have a fixed precedence, and the good-frame counter receives only frames that no error counter claimed.

Software reads the counters through a byte-wide read port. Each counter occupies four consecutive byte addresses, and there is no write path. Only a hard reset (asynchronous, active low) or a soft reset (synchronous, active high) returns the counters to zero.

Top module: `rx_stat_bank`

## Requirements
- R1: A counter changes only on a cycle where `eofStb` is high, and at most one counter increments per strobe. With the strobe low, all counters hold regardless of the flags.
- R2: The precedence is underrun, then overflow, then minimum length, then maximum length, then FCS/HEC, then good. When several flags are set, only the highest cause counts.
- R3: A frame qualifies as an FCS/HEC error when (`fcsErr` or `hecErr`) is set with `chkEn` high, or when `ctrlFlagErr` is set. `ctrlFlagErr` qualifies even with `chkEn` low. With `chkEn` low, an FCS or HEC error alone does not qualify.
- R4: The good-frame counter increments only for a frame that increments no error counter. A frame that carries any qualifying error never counts as good.
- R5: Each counter is CNT_W bits wide (24 by default). An increment from the all-ones value wraps the counter to zero.
- R6: Counter k sits at byte addresses 4k..4k+3. Offset 0 returns bits 7:0, offset 1 bits 15:8 and offset 2 bits 23:16. Offset 3 always reads zero. The values of k are 0 underrun, 1 overflow, 2 minimum length, 3 maximum length, 4 FCS/HEC, 5 good. Addresses 24 to 31 read zero.
- R7: `rdData` presents the addressed byte one cycle after `rdAddr` is applied. A read that coincides with an increment of the same counter returns the value the counter had before the increment.
- R8: A hard reset clears all counters and `rdData` at once. A soft reset clears all counters at the next clock edge, and it takes priority over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous hard reset, active low |
| softRst | input | 1 | Synchronous soft reset, active high |
| eofStb | input | 1 | One-cycle end-of-frame strobe |
| underrunErr | input | 1 | Frame hit a FIFO underrun |
| overflowErr | input | 1 | Frame hit a FIFO overflow |
| minLenErr | input | 1 | Frame shorter than the minimum |
| maxLenErr | input | 1 | Frame longer than the maximum |
| fcsErr | input | 1 | Frame check sequence mismatch |
| hecErr | input | 1 | Header error check mismatch |
| ctrlFlagErr | input | 1 | Frame held an unrecognized control flag |
| chkEn | input | 1 | Enables FCS and HEC error qualification |
| rdAddr | input | 5 | Byte read address |
| rdData | output | 8 | Registered read byte |

## Verification
A wrong classification shows up in a single frame, because the whole error goes into one counter. One unit lands in the wrong counter and one unit is missing from the right one, so the fault is visible on the next read of either address. A lost or doubled increment, or a bad wrap, leaves a counter off from the count of frames driven. This stays visible until the next reset. The wrap itself is reached on a narrowed instance so that it falls within a short run. A wrong read path shows up one cycle after the address. It appears as a shifted byte lane, a nonzero fourth byte, or a torn value on a read taken in the same cycle as an increment.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int NUM_CNT = 6;
  localparam int BYTES_PER_CNT = 4;
  localparam int ADDR_W = $clog2(NUM_CNT * BYTES_PER_CNT);

  typedef enum logic [2:0] {
    CNT_UNDERRUN = 3'd0,
    CNT_OVERFLOW = 3'd1,
    CNT_MINLEN   = 3'd2,
    CNT_MAXLEN   = 3'd3,
    CNT_FCSHEC   = 3'd4,
    CNT_GOOD     = 3'd5
  } cnt_idx_e;

  typedef struct packed {
    logic [NUM_CNT-1:0] inc;
    logic               clr;
  } stat_strobe_t;
endpackage

// File: rtl/rx_stat_classify.sv
module rx_stat_classify
  import rx_stat_pkg::*;
(
  input  logic         softRst,
  input  logic         eofStb,
  input  logic         underrunErr,
  input  logic         overflowErr,
  input  logic         minLenErr,
  input  logic         maxLenErr,
  input  logic         fcsErr,
  input  logic         hecErr,
  input  logic         ctrlFlagErr,
  input  logic         chkEn,
  output stat_strobe_t strb
);
  logic [NUM_CNT-1:0] cause;
  logic [NUM_CNT-1:0] pick;

  always_comb begin
    cause = '0;
    cause[CNT_UNDERRUN] = underrunErr;
    cause[CNT_OVERFLOW] = overflowErr;
    cause[CNT_MINLEN]   = minLenErr;
    cause[CNT_MAXLEN]   = maxLenErr;
    cause[CNT_FCSHEC]   = ((fcsErr | hecErr) & chkEn) | ctrlFlagErr;
    cause[CNT_GOOD]     = 1'b1;
  end

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int k = NUM_CNT - 1; k >= 0; k--) begin
      if (cause[k]) pick = NUM_CNT'(1) << k;
    end
  end

  always_comb begin
    strb.clr = softRst;
    strb.inc = (eofStb && !softRst) ? pick : '0;
  end
endmodule

// File: rtl/rx_stat_counters.sv
module rx_stat_counters
  import rx_stat_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                     clk,
  input  logic                     hardRstN,
  input  stat_strobe_t             strb,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [7:0]               rdData,
  output logic [NUM_CNT*CNT_W-1:0] cntFlat
);
  localparam int SEL_W = ADDR_W - 2;
  localparam int WIDE_W = 8 * (BYTES_PER_CNT - 1);

  logic [CNT_W-1:0] cnt [NUM_CNT];

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    always_ff @(posedge clk or negedge hardRstN) begin
      if (!hardRstN)        cnt[k] <= '0;
      else if (strb.clr)    cnt[k] <= '0;
      else if (strb.inc[k]) cnt[k] <= cnt[k] + 1'b1;
    end
    assign cntFlat[k*CNT_W +: CNT_W] = cnt[k];
  end

  logic [SEL_W-1:0]  sel;
  logic [1:0]        off;
  logic [WIDE_W-1:0] wide;
  logic [7:0]        byteSel;

  always_comb begin
    sel  = rdAddr[ADDR_W-1:2];
    off  = rdAddr[1:0];
    wide = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (sel == SEL_W'(k)) wide = WIDE_W'(cnt[k]);
    end
    case (off)
      2'd0:    byteSel = wide[7:0];
      2'd1:    byteSel = wide[15:8];
      2'd2:    byteSel = wide[23:16];
      default: byteSel = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) rdData <= 8'h00;
    else           rdData <= byteSel;
  end
endmodule

// File: rtl/rx_stat_bank.sv
module rx_stat_bank
  import rx_stat_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  logic              eofStb,
  input  logic              underrunErr,
  input  logic              overflowErr,
  input  logic              minLenErr,
  input  logic              maxLenErr,
  input  logic              fcsErr,
  input  logic              hecErr,
  input  logic              ctrlFlagErr,
  input  logic              chkEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  stat_strobe_t             strb;
  logic [NUM_CNT*CNT_W-1:0] cntFlat;

  rx_stat_classify u_classify (
    .softRst(softRst), .eofStb(eofStb),
    .underrunErr(underrunErr), .overflowErr(overflowErr),
    .minLenErr(minLenErr), .maxLenErr(maxLenErr),
    .fcsErr(fcsErr), .hecErr(hecErr), .ctrlFlagErr(ctrlFlagErr),
    .chkEn(chkEn), .strb(strb)
  );

  rx_stat_counters #(.CNT_W(CNT_W)) u_counters (
    .clk(clk), .hardRstN(hardRstN), .strb(strb),
    .rdAddr(rdAddr), .rdData(rdData), .cntFlat(cntFlat)
  );
endmodule

// File: rtl/rx_stat_bank_chk.sv
module rx_stat_bank_chk
  import rx_stat_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic                     clk,
  input logic                     hardRstN,
  input logic                     softRst,
  input logic                     eofStb,
  input logic [ADDR_W-1:0]        rdAddr,
  input logic [7:0]               rdData,
  input logic [NUM_CNT-1:0]       incVec,
  input logic [NUM_CNT*CNT_W-1:0] cntFlat
);
  AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (!hardRstN)
    $onehot0(incVec)); // R1
  AST_NO_STROBE_NO_INC: assert property (@(posedge clk) disable iff (!hardRstN)
    !eofStb |-> (incVec == '0)); // R1
  AST_FRAME_COUNTED: assert property (@(posedge clk) disable iff (!hardRstN)
    (eofStb && !softRst) |-> ($countones(incVec) == 1)); // R4
  AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (!hardRstN)
    ($past(rdAddr[1:0]) == 2'd3) |-> (rdData == 8'h00)); // R6
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!hardRstN)
    $past(softRst) |-> (cntFlat == '0)); // R8

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!hardRstN)
      ($past(incVec[k]) && !$past(softRst)) |->
      (cntFlat[k*CNT_W +: CNT_W] == CNT_W'($past(cntFlat[k*CNT_W +: CNT_W]) + 1'b1))); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (!hardRstN)
      (!$past(incVec[k]) && !$past(softRst)) |-> $stable(cntFlat[k*CNT_W +: CNT_W])); // R1
  end
endmodule

bind rx_stat_bank rx_stat_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .eofStb(eofStb),
  .rdAddr(rdAddr), .rdData(rdData), .incVec(strb.inc), .cntFlat(cntFlat)
);

// File: tb/rx_stat_bank_tb.sv
module rx_stat_bank_tb;
  logic clk = 1'b0;
  logic hardRstN = 1'b0;
  logic softRst = 1'b0;
  logic eofStb = 1'b0;
  logic [6:0] flg = '0; // [0]und [1]ovf [2]min [3]max [4]fcs [5]hec [6]ctrl
  logic chkEn = 1'b1;
  logic [4:0] rdAddr = '0;
  logic [7:0] rdData, nRd;

  int nChk = 0;
  int nFail = 0;
  int expc [6];

  always #4 clk = ~clk;

  rx_stat_bank u_dut (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .eofStb(eofStb),
    .underrunErr(flg[0]), .overflowErr(flg[1]), .minLenErr(flg[2]), .maxLenErr(flg[3]),
    .fcsErr(flg[4]), .hecErr(flg[5]), .ctrlFlagErr(flg[6]), .chkEn(chkEn),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  rx_stat_bank #(.CNT_W(9)) u_nar (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .eofStb(eofStb),
    .underrunErr(flg[0]), .overflowErr(flg[1]), .minLenErr(flg[2]), .maxLenErr(flg[3]),
    .fcsErr(flg[4]), .hecErr(flg[5]), .ctrlFlagErr(flg[6]), .chkEn(chkEn),
    .rdAddr(rdAddr), .rdData(nRd)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rdByte(input logic [4:0] a, output logic [7:0] d, output logic [7:0] n);
    @(negedge clk); rdAddr = a;
    @(posedge clk);
    @(negedge clk); d = rdData; n = nRd;
  endtask

  task automatic rdCnt(input int k, output int v);
    logic [7:0] b0, b1, b2, b3, nn;
    rdByte(5'(4*k),   b0, nn);
    rdByte(5'(4*k+1), b1, nn);
    rdByte(5'(4*k+2), b2, nn);
    rdByte(5'(4*k+3), b3, nn);
    chk("R6 fourth byte", b3, 0);
    v = {b2, b1, b0};
  endtask

  function automatic int classOf(input logic [6:0] f, input logic ce);
    if (f[0]) return 0;
    if (f[1]) return 1;
    if (f[2]) return 2;
    if (f[3]) return 3;
    if (((f[4] | f[5]) & ce) | f[6]) return 4;
    return 5;
  endfunction

  task automatic frame(input logic [6:0] f, input logic ce);
    @(negedge clk); flg = f; chkEn = ce; eofStb = 1'b1;
    @(negedge clk); eofStb = 1'b0; flg = '0;
    expc[classOf(f, ce)] = (expc[classOf(f, ce)] + 1) & 24'hFFFFFF;
  endtask

  task automatic checkAll(input string req);
    int v;
    for (int k = 0; k < 6; k++) begin
      rdCnt(k, v);
      chk(req, v, expc[k]);
    end
  endtask

  task automatic t_reset;
    for (int k = 0; k < 6; k++) expc[k] = 0;
    checkAll("R8 reset state zero");
  endtask

  task automatic t_single;
    frame(7'b0000001, 1); frame(7'b0000010, 1); frame(7'b0000100, 1);
    frame(7'b0001000, 1); frame(7'b0010000, 1); frame(7'b0000000, 1);
    frame(7'b0000000, 1);
    checkAll("R4 one cause per counter");
  endtask

  task automatic t_priority;
    frame(7'b1111111, 1); frame(7'b1111110, 1); frame(7'b1111100, 1);
    frame(7'b1111000, 1); frame(7'b0110000, 1);
    checkAll("R2 precedence");
  endtask

  task automatic t_chk_en;
    frame(7'b0010000, 0); frame(7'b0100000, 0); frame(7'b1000000, 0);
    frame(7'b0100000, 1);
    checkAll("R3 check enable and control flag");
  endtask

  task automatic t_no_strobe;
    @(negedge clk); flg = 7'b1111111; chkEn = 1;
    repeat (3) @(negedge clk);
    flg = '0;
    checkAll("R1 flags without strobe ignored");
  endtask

  task automatic t_addr_map;
    logic [7:0] d, n;
    for (int a = 24; a < 32; a++) begin
      rdByte(5'(a), d, n);
      chk("R6 unused address zero", d, 0);
    end
  endtask

  task automatic t_coincide;
    int g = expc[5];
    @(negedge clk); rdAddr = 5'd20; flg = '0; eofStb = 1'b1;
    @(negedge clk); eofStb = 1'b0;
    chk("R7 read with increment gives old value", rdData, g & 8'hFF);
    @(negedge clk);
    chk("R7 next read gives new value", rdData, (g + 1) & 8'hFF);
    expc[5] = g + 1;
  endtask

  task automatic t_soft;
    @(negedge clk); softRst = 1'b1; eofStb = 1'b1;
    @(negedge clk); softRst = 1'b0; eofStb = 1'b0;
    for (int k = 0; k < 6; k++) expc[k] = 0;
    checkAll("R8 soft reset wins over increment");
  endtask

  task automatic t_hard;
    frame(7'b0000001, 1); frame(7'b0000000, 1);
    @(negedge clk); hardRstN = 1'b0;
    #1 chk("R8 hard reset clears read data at once", rdData, 0);
    @(negedge clk); hardRstN = 1'b1;
    for (int k = 0; k < 6; k++) expc[k] = 0;
    checkAll("R8 hard reset clears counters");
  endtask

  task automatic t_wrap;
    logic [7:0] d, n;
    for (int i = 0; i < 511; i++) frame(7'b0000000, 1);
    rdByte(5'd20, d, n); chk("R5 narrow low byte", n, 8'hFF);
    rdByte(5'd21, d, n); chk("R5 narrow high byte", n, 8'h01);
    frame(7'b0000000, 1);
    rdByte(5'd20, d, n); chk("R5 narrow wrap low", n, 0);
    rdByte(5'd21, d, n); chk("R5 narrow wrap high", n, 0);
    chk("R5 wide counter carries", d, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    hardRstN = 1'b1;
    t_reset; t_single; t_priority; t_chk_en; t_no_strobe;
    t_addr_map; t_coincide; t_soft; t_hard; t_wrap;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #1000000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule